// File: doc/BRIEF.md
# Five-Channel Masked Compare Timer

This block is a word-addressed timer peripheral. A 32-bit time base counts up by one every clock and can be loaded through the register port. Five channels each hold a compare value and a compare mask, and each watches the time base. A channel matches when the time base equals its compare value in every bit its mask selects. Only the upper five bits of both registers are kept, so only the top five bits of the time base take part in the compare.

Each channel drives one output pin. When the pin is enabled, it shows a programmable level while the channel matches and the opposite level while it does not. When the start of a match is enabled for that channel, it latches a status bit. Software can also set status bits with a write-one-to-set register and clear them with a write-one-to-clear register. A channel's interrupt line is high while both its status bit and its interrupt-mask bit are set. An interrupt controller outside the block consumes the five lines.

Reads complete one cycle after they are requested. Writes take effect at the clock edge that samples them.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every control, compare, mask and status register reads zero, and all five pins and all five interrupt lines are low.
- R2: The time base at offset 0x00 increments once per clock. A write loads the written value, and it counts on from that value on the following cycles. A read returns the value held in the cycle the read is sampled.
- R3: Output enable (0x04) and output level (0x08) keep only bits 31:27, with channel n at bit 27+n. Compare registers at 0x80+4n and mask registers at 0xC0+4n keep only bits 31:27, and all other written bits read back as zero.
- R4: A channel matches when (time base AND mask) equals (compare AND mask), using bits 31:27 only. A mask of zero therefore always matches.
- R5: A channel pin is low while its enable bit is clear. While the bit is set, the pin equals the level bit during a match and its inverse otherwise. The pin follows the time base with one cycle of delay.
- R6: Interrupt enable (0x18) keeps bits 15:11, with channel n at bit 11+n. When a match starts on a channel whose enable bit is set, its status bit is set. A match that starts while the enable bit is clear leaves status unchanged.
- R7: Writing 0x10 ORs bits 15:11 of the written data into status. Both 0x10 and 0x14 read back the status.
- R8: Writing 0x14 clears the status bits written as one (bits 15:11). A match start in the same cycle still sets its bit.
- R9: Interrupt mask (0x0C) keeps bits 15:11. Interrupt line n is high exactly when status bit n and mask bit n are both set, starting in the cycle after the write that makes it so.
- R10: Reads of unmapped offsets, of offsets at or above 0xD4, and of addresses that are not word aligned return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and releases synchronously inside the block |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| tmr_out | output | 5 | Channel pins, bit n = channel n |
| tmr_irq | output | 5 | Channel interrupt lines, bit n = channel n |

## Verification
Each result has a fixed latency:
- Read data arrives one cycle after the request.
- A register write changes the interrupt lines in the very next cycle.
- A pin follows a time-base change two edges later: the load edge, then the match register.
- A status bit set by a match appears one edge after the time base reaches the compare window.

The bench drives on the falling edge and pushes each expected read into a queue. A monitor pops that queue whenever read-valid is seen. Pin and interrupt checks sample only after idle gaps that exceed these latencies. Time-base reads are made back to back after a load, so their expected values are exact counts.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CT_NCH     = 5;
  localparam int CT_DW      = 32;
  localparam int CT_AW      = 8;
  localparam int CT_KW      = 5;   // kept compare/mask bits (top of word)
  localparam int CT_OUT_LSB = 27;  // pin field low bit
  localparam int CT_IRQ_LSB = 11;  // interrupt field low bit

  localparam int OFF_TB   = 'h00;
  localparam int OFF_OEN  = 'h04;
  localparam int OFF_LVL  = 'h08;
  localparam int OFF_IMSK = 'h0C;
  localparam int OFF_SSET = 'h10;
  localparam int OFF_SCLR = 'h14;
  localparam int OFF_IEN  = 'h18;
  localparam int OFF_CMP  = 'h80;
  localparam int OFF_MSK  = 'hC0;
endpackage

// File: rtl/ct_timebase.sv
module ct_timebase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count
);
  logic [DW-1:0] count_n;

  always_comb begin
    count_n = load ? load_val : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end

  // R2: free running count
  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> count == $past(count) + 1'b1);
  // R2: load value lands
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
endmodule

// File: rtl/ct_channel.sv
module ct_channel #(
  parameter int DW = 32,
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tb,
  input  logic [KW-1:0] cmp_val,
  input  logic [KW-1:0] mask_val,
  input  logic          oe,
  input  logic          lvl,
  output logic          pin,
  output logic          rise
);
  logic match_c;
  logic match_q;

  always_comb begin
    match_c = ((tb[DW-1 -: KW] ^ cmp_val) & mask_val) == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_c;
  end

  assign rise = match_c & ~match_q;
  assign pin  = oe & ~(match_q ^ lvl);
endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int DW      = CT_DW,
  parameter int AW      = CT_AW,
  parameter int NCH     = CT_NCH,
  parameter int KW      = CT_KW,
  parameter int OUT_LSB = CT_OUT_LSB,
  parameter int IRQ_LSB = CT_IRQ_LSB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic                   bus_rvalid,
  input  logic [DW-1:0]          tb,
  input  logic [NCH-1:0]         rise,
  output logic                   tb_load,
  output logic [DW-1:0]          tb_val,
  output logic [NCH-1:0]         oen,
  output logic [NCH-1:0]         lvl,
  output logic [NCH-1:0]         imsk,
  output logic [NCH-1:0]         ien,
  output logic [NCH-1:0]         status,
  output logic [NCH-1:0][KW-1:0] cmp,
  output logic [NCH-1:0][KW-1:0] msk
);
  logic                   aligned, wr, rd, hit;
  logic [NCH-1:0]         wb_out, wb_irq;
  logic [DW-1:0]          rd_n;
  logic [NCH-1:0]         oen_n, lvl_n, imsk_n, ien_n, st_n;
  logic [NCH-1:0][KW-1:0] cmp_n, msk_n;

  assign tb_val = bus_wdata;

  always_comb begin
    aligned = bus_addr[1:0] == 2'b00;
    wr      = bus_sel & bus_we & aligned;
    rd      = bus_sel & ~bus_we;
    wb_out  = bus_wdata[OUT_LSB +: NCH];
    wb_irq  = bus_wdata[IRQ_LSB +: NCH];
    oen_n   = oen;
    lvl_n   = lvl;
    imsk_n  = imsk;
    ien_n   = ien;
    st_n    = status;
    cmp_n   = cmp;
    msk_n   = msk;
    tb_load = 1'b0;
    hit     = 1'b0;
    rd_n    = '0;
    if (aligned) begin
      if (bus_addr == AW'(OFF_TB)) begin
        hit = 1'b1; rd_n = tb; tb_load = wr;
      end
      if (bus_addr == AW'(OFF_OEN)) begin
        hit = 1'b1; rd_n[OUT_LSB +: NCH] = oen;
        if (wr) oen_n = wb_out;
      end
      if (bus_addr == AW'(OFF_LVL)) begin
        hit = 1'b1; rd_n[OUT_LSB +: NCH] = lvl;
        if (wr) lvl_n = wb_out;
      end
      if (bus_addr == AW'(OFF_IMSK)) begin
        hit = 1'b1; rd_n[IRQ_LSB +: NCH] = imsk;
        if (wr) imsk_n = wb_irq;
      end
      if (bus_addr == AW'(OFF_SSET)) begin
        hit = 1'b1; rd_n[IRQ_LSB +: NCH] = status;
        if (wr) st_n = status | wb_irq;
      end
      if (bus_addr == AW'(OFF_SCLR)) begin
        hit = 1'b1; rd_n[IRQ_LSB +: NCH] = status;
        if (wr) st_n = status & ~wb_irq;
      end
      if (bus_addr == AW'(OFF_IEN)) begin
        hit = 1'b1; rd_n[IRQ_LSB +: NCH] = ien;
        if (wr) ien_n = wb_irq;
      end
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == AW'(OFF_CMP + 4*n)) begin
          hit = 1'b1; rd_n[DW-1 -: KW] = cmp[n];
          if (wr) cmp_n[n] = bus_wdata[DW-1 -: KW];
        end
        if (bus_addr == AW'(OFF_MSK + 4*n)) begin
          hit = 1'b1; rd_n[DW-1 -: KW] = msk[n];
          if (wr) msk_n[n] = bus_wdata[DW-1 -: KW];
        end
      end
    end
    // hardware event wins over a same-cycle clear
    st_n = st_n | (rise & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oen    <= '0;
      lvl    <= '0;
      imsk   <= '0;
      ien    <= '0;
      status <= '0;
      cmp    <= '0;
      msk    <= '0;
    end else begin
      if (wr) begin
        oen  <= oen_n;
        lvl  <= lvl_n;
        imsk <= imsk_n;
        ien  <= ien_n;
        cmp  <= cmp_n;
        msk  <= msk_n;
      end
      status <= st_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= hit ? rd_n : '0;
    end
  end

  // R7: set-write bits present next cycle
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == AW'(OFF_SSET))
      |=> ($past(bus_wdata[IRQ_LSB +: NCH]) & ~status) == '0);
  // R8: cleared bits gone unless an event fired
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == AW'(OFF_SCLR))
      |=> (status & $past(bus_wdata[IRQ_LSB +: NCH] & ~(rise & ien))) == '0);
  // R6: enabled match start latches status
  a_r6_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & ien)) |=> ($past(rise & ien) & ~status) == '0);
  // R10: unmapped read returns zero
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !hit) |=> (bus_rvalid && bus_rdata == '0));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import ct_pkg::*;
#(
  parameter int DW      = CT_DW,
  parameter int AW      = CT_AW,
  parameter int NCH     = CT_NCH,
  parameter int KW      = CT_KW,
  parameter int OUT_LSB = CT_OUT_LSB,
  parameter int IRQ_LSB = CT_IRQ_LSB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  output logic [NCH-1:0] tmr_out,
  output logic [NCH-1:0] tmr_irq
);
  logic [1:0]             rsync;
  logic                   rst_i_n;
  logic [DW-1:0]          tb, tb_val;
  logic                   tb_load;
  logic [NCH-1:0]         rise, oen, lvl, imsk, ien, status;
  logic [NCH-1:0][KW-1:0] cmp, msk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  ct_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst_n(rst_i_n), .load(tb_load), .load_val(tb_val), .count(tb)
  );

  ct_regs #(
    .DW(DW), .AW(AW), .NCH(NCH), .KW(KW), .OUT_LSB(OUT_LSB), .IRQ_LSB(IRQ_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tb(tb), .rise(rise), .tb_load(tb_load), .tb_val(tb_val),
    .oen(oen), .lvl(lvl), .imsk(imsk), .ien(ien), .status(status),
    .cmp(cmp), .msk(msk)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ct_channel #(.DW(DW), .KW(KW)) u_ch (
      .clk(clk), .rst_n(rst_i_n), .tb(tb),
      .cmp_val(cmp[n]), .mask_val(msk[n]),
      .oe(oen[n]), .lvl(lvl[n]),
      .pin(tmr_out[n]), .rise(rise[n])
    );
  end

  assign tmr_irq = status & imsk;

  // R9: zero mask written -> lines low next cycle
  a_r9_mask_off: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && bus_we && bus_addr == AW'(OFF_IMSK) &&
     bus_wdata[IRQ_LSB +: NCH] == '0) |=> tmr_irq == '0);
  // R1: pins low while all enables are clear
  a_r1_pins_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (oen == '0) |-> tmr_out == '0);
endmodule

// File: tb/sim_cmp_timer.sv
`timescale 1ns/1ps
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [4:0]  tmr_out, tmr_irq;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tmr_out(tmr_out), .tmr_irq(tmr_irq)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard for read responses
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected read", bus_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(5);

    // R1 reset state
    check(tmr_out == 5'b0, "R1 pins", {27'b0, tmr_out}, 32'h0);
    check(tmr_irq == 5'b0, "R1 irq", {27'b0, tmr_irq}, 32'h0);
    brd(8'h04, 32'h0, "R1 oen");
    brd(8'h08, 32'h0, "R1 lvl");
    brd(8'h0C, 32'h0, "R1 imsk");
    brd(8'h10, 32'h0, "R1 status");
    brd(8'h18, 32'h0, "R1 ien");
    brd(8'h80, 32'h0, "R1 cmp0");
    brd(8'hD0, 32'h0, "R1 msk4");

    // R2 time base load and count
    bwr(8'h00, 32'h1234_0000);
    brd(8'h00, 32'h1234_0000, "R2 load");
    brd(8'h00, 32'h1234_0001, "R2 count");

    // R3 field masking
    bwr(8'h04, 32'hFFFF_FFFF);
    brd(8'h04, 32'hF800_0000, "R3 oen field");
    bwr(8'h04, 32'h0);
    bwr(8'h84, 32'hFFFF_FFFF);
    brd(8'h84, 32'hF800_0000, "R3 cmp1 field");
    bwr(8'hC4, 32'h1234_5678);
    brd(8'hC4, 32'h1000_0000, "R3 msk1 field");
    bwr(8'h84, 32'h0);
    bwr(8'hC4, 32'h0);

    // R10 unmapped, out of window, misaligned
    brd(8'h40, 32'h0, "R10 hole read");
    bwr(8'h40, 32'hFFFF_FFFF);
    brd(8'h40, 32'h0, "R10 hole write");
    bwr(8'h06, 32'hFFFF_FFFF);
    brd(8'h04, 32'h0, "R10 misaligned write");
    brd(8'hD4, 32'h0, "R10 past window");

    // R4 / R5 pins
    bwr(8'hC0, 32'hF800_0000);
    bwr(8'h80, 32'h0800_0000);
    bwr(8'h08, 32'h1800_0000);
    bwr(8'h04, 32'h0800_0000);
    bwr(8'h00, 32'h0800_0000);
    idle(4);
    check(tmr_out == 5'b00001, "R5 match drives level", {27'b0, tmr_out}, 32'h1);
    bwr(8'h04, 32'h1800_0000);
    idle(3);
    check(tmr_out == 5'b00011, "R4 zero mask matches", {27'b0, tmr_out}, 32'h3);
    bwr(8'h08, 32'h1000_0000);
    idle(3);
    check(tmr_out == 5'b00010, "R5 level low on match", {27'b0, tmr_out}, 32'h2);
    bwr(8'h00, 32'h0);
    idle(4);
    check(tmr_out == 5'b00011, "R5 mismatch inverts", {27'b0, tmr_out}, 32'h3);
    bwr(8'hC0, 32'h8000_0000);
    idle(3);
    check(tmr_out == 5'b00010, "R4 partial mask", {27'b0, tmr_out}, 32'h2);
    bwr(8'h04, 32'h0);
    idle(3);
    check(tmr_out == 5'b00000, "R5 disabled low", {27'b0, tmr_out}, 32'h0);

    // R6 match start sets status
    bwr(8'h88, 32'h1000_0000);
    bwr(8'hC8, 32'hF800_0000);
    bwr(8'h0C, 32'h0000_2000);
    bwr(8'h18, 32'h0000_2000);
    bwr(8'h00, 32'h0FFF_FFF0);
    idle(30);
    brd(8'h10, 32'h0000_2000, "R6 status from match");
    idle(1);
    check(tmr_irq == 5'b00100, "R9 irq ch2", {27'b0, tmr_irq}, 32'h4);

    // R8 clear
    bwr(8'h14, 32'h0000_2000);
    idle(1);
    check(tmr_irq == 5'b00000, "R8 irq after clear", {27'b0, tmr_irq}, 32'h0);
    brd(8'h10, 32'h0, "R8 status cleared");

    // R7 set
    bwr(8'h10, 32'hFFFF_FFFF);
    brd(8'h14, 32'h0000_F800, "R7 set all");
    idle(1);
    check(tmr_irq == 5'b00100, "R9 mask gates", {27'b0, tmr_irq}, 32'h4);
    bwr(8'h0C, 32'hFFFF_FFFF);
    idle(1);
    check(tmr_irq == 5'b11111, "R9 all unmasked", {27'b0, tmr_irq}, 32'h1F);
    brd(8'h0C, 32'h0000_F800, "R9 imsk field");
    bwr(8'h14, 32'h0000_0800);
    brd(8'h10, 32'h0000_F000, "R8 partial clear");
    idle(1);
    check(tmr_irq == 5'b11110, "R8 irq partial", {27'b0, tmr_irq}, 32'h1E);
    bwr(8'h0C, 32'h0);
    idle(1);
    check(tmr_irq == 5'b00000, "R9 masked off", {27'b0, tmr_irq}, 32'h0);
    brd(8'h10, 32'h0000_F000, "R9 status kept");

    // R6 disabled channel ignores match start
    bwr(8'h14, 32'hFFFF_FFFF);
    bwr(8'h18, 32'h0);
    bwr(8'h00, 32'h0FFF_FFF0);
    idle(30);
    brd(8'h10, 32'h0, "R6 no status when disabled");

    idle(4);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule